// File: doc/BRIEF.md
# OR-Merged Function-Code ALU Slice

This block is the arithmetic and boolean slice of a small 16-bit processor. A 4-bit function code selects the operation. An internal decoder turns that code into a set of lane enables and control bits. The block has two boolean lanes, an adder lane and a pass lane. Each lane is forced to zero when its enable is low. The result is the bitwise OR of all the lanes, so no result multiplexer is used. OR needs no lane of its own: it enables the AND lane and the XOR lane together, because (A&B)|(A^B) equals A|B.

One invert-B control serves ANDN, SUB and both compares, and the same control supplies the adder carry-in. The block also drives two strobes for the register file and the flag logic: a register-writeback strobe and a carry-write strobe. For shift, rotate, I/O, SET, CALL and load-constant codes the block does not compute those operations. It only passes B through or drives zero, and it drives the two strobes.

The block is purely combinational. Every output follows the inputs with no register stage.

Top module: `alu_or_merge`

## Requirements
- R1: Boolean codes give result OR=0000 A|B, XOR=0001 A^B, AND=0010 A&B, ANDN=0011 A&~B.
- R2: Codes 1000, 1001 and 1100 give result equal to B.
- R3: Codes 1010, 1011, 1101, 1110 and 1111 give result 0.
- R4: Code 0111 gives result (A+B) mod 2^16 and carry_out equal to bit 16 of A+B. Code 0110 gives result (A-B) mod 2^16 and carry_out equal to 1 exactly when A>=B as unsigned numbers.
- R5: Code 0100 (unsigned compare) gives result (A-B) mod 2^16 and carry_out equal to 1 exactly when A>=B as unsigned numbers.
- R6: Code 0101 (signed compare) gives result (A-B) mod 2^16 and carry_out equal to 1 exactly when A<B as two's-complement numbers.
- R7: reg_wr_en is 0 for codes 0100, 0101, 1110 and 1111, and 1 for every other code.
- R8: carry_wr_en is 1 for codes 0100 to 0111. It is also 1 for code 1011 when rot_via_c is 1. It is 0 in every other case.
- R9: For codes 0000 to 0011 and 1000 to 1111, carry_out equals carry_in.
- R10: Every output settles from the current inputs alone. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| func | input | 4 | Function code |
| carry_in | input | 1 | Current carry flag, returned unchanged by non-arithmetic codes |
| rot_via_c | input | 1 | For code 1011, selects the rotate-through-carry variant |
| result | output | 16 | OR of the gated lane values |
| carry_out | output | 1 | Adder carry, inverted borrow, or signed less-than, depending on code |
| reg_wr_en | output | 1 | Register writeback strobe |
| carry_wr_en | output | 1 | Carry flag write strobe |

## Verification
All results are due in the same cycle as the stimulus, with zero register stages. The driver applies inputs on a rising edge of the bench clock and queues the expected values. The monitor pops the queue and compares on the following falling edge, after the combinational paths have settled. Every code is swept against corner operands (0, 0xFFFF, 0x8000, 0x7FFF), with both values of rot_via_c and both values of carry_in, and then against random operands.

// File: rtl/alu_or_pkg.sv
`timescale 1ns/1ps
// Package: shared function codes and decoded control bundle for the
// OR-merged ALU slice. Assumes a 4-bit function code.
package alu_or_pkg;

    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_OR    = 4'b0000,
        FN_XOR   = 4'b0001,
        FN_AND   = 4'b0010,
        FN_ANDN  = 4'b0011,
        FN_CMPU  = 4'b0100,
        FN_CMPS  = 4'b0101,
        FN_SUB   = 4'b0110,
        FN_ADD   = 4'b0111,
        FN_SET   = 4'b1000,
        FN_CALL  = 4'b1001,
        FN_SHIFT = 4'b1010,
        FN_ROT   = 4'b1011,
        FN_LDC   = 4'b1100,
        FN_IN    = 4'b1101,
        FN_OUT   = 4'b1110,
        FN_INV   = 4'b1111
    } alu_func_e;

    // Decoded controls shared by all lanes.
    typedef struct packed {
        logic neg;        // invert B, also the adder carry-in
        logic and_en;     // AND lane enable
        logic xor_en;     // XOR lane enable
        logic pass_en;    // pass-B lane enable
        logic add_en;     // adder lane enable
        logic cmp_signed; // adder reports signed less-than
        logic wb_en;      // register writeback strobe
        logic cry_wr;     // carry write strobe
    } alu_ctl_t;

endpackage

// File: rtl/alu_decoder.sv
`timescale 1ns/1ps
// Module: alu_decoder
// Turns the 4-bit function code into lane enables and strobes with
// sum-of-products logic (no lookup table). Assumes func is the raw code
// and rot_via_c only matters for the rotate code.
module alu_decoder
    import alu_or_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  logic              rot_via_c,
    output alu_ctl_t          ctl
);

    logic f0, f1, f2, f3;
    logic bool_grp;
    logic rot_code;

    // Split the code into named bits and group terms.
    always_comb begin
        f0       = func[0];
        f1       = func[1];
        f2       = func[2];
        f3       = func[3];
        bool_grp = ~f3 & ~f2;
        rot_code = f3 & ~f2 & f1 & f0;
    end

    // Product terms for every decoded control.
    always_comb begin
        ctl.add_en     = f2 & ~f3;
        ctl.neg        = (bool_grp & f1 & f0) | (f2 & ~f3 & ~(f1 & f0));
        ctl.and_en     = bool_grp & ~(~f1 & f0);
        ctl.xor_en     = bool_grp & ~f1;
        ctl.pass_en    = f3 & ~f1 & ~(f2 & f0);
        ctl.cmp_signed = (f2 & ~f3) & (f0 & ~f1);
        ctl.wb_en      = ~f2 | (f3 & ~f1) | (~f3 & f1);
        ctl.cry_wr     = (f2 & ~f3) | (rot_code & rot_via_c);
    end

    // Lane exclusivity: the adder never shares the OR with other lanes.
    always_comb begin
        if (ctl.add_en) begin
            AST_ADDER_ALONE: assert (!ctl.and_en && !ctl.xor_en && !ctl.pass_en) // R4
                else $error("adder lane overlaps another lane");
        end
        if (ctl.cmp_signed) begin
            AST_SCMP_ONLY_0101: assert (func == FN_CMPS) // R6
                else $error("signed compare decoded for wrong code");
        end
    end

endmodule

// File: rtl/alu_logic_lane.sv
`timescale 1ns/1ps
// Module: alu_logic_lane
// Gated AND, XOR and pass-B lanes. Each lane drives zero when disabled,
// so the caller can merge lanes with OR. Assumes b_eff is B already
// optionally inverted.
module alu_logic_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_raw,
    input  logic [W-1:0] b_eff,
    input  logic         and_en,
    input  logic         xor_en,
    input  logic         pass_en,
    output logic [W-1:0] lane_or
);

    // Per-bit gated lanes and their local OR.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic and_bit, xor_bit, pass_bit;
        always_comb begin
            and_bit    = and_en  & a[i] & b_eff[i];
            xor_bit    = xor_en  & (a[i] ^ b_eff[i]);
            pass_bit   = pass_en & b_raw[i];
            lane_or[i] = and_bit | xor_bit | pass_bit;
        end
    end

    // A disabled lane set must contribute nothing.
    always_comb begin
        if (!and_en && !xor_en && !pass_en) begin
            AST_LOGIC_IDLE_ZERO: assert (lane_or == '0) // R3
                else $error("idle logic lanes not zero");
        end
    end

endmodule

// File: rtl/alu_add_lane.sv
`timescale 1ns/1ps
// Module: alu_add_lane
// Gated adder lane. Computes a + b_eff + cin. The flag output is the
// carry, or the signed less-than when cmp_signed is set. Assumes that for
// subtract b_eff is ~B and cin is 1.
module alu_add_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    input  logic         en,
    input  logic         cmp_signed,
    output logic [W-1:0] lane,
    output logic         flag
);

    localparam int MSB = W - 1;

    logic [W:0] sum;
    logic       ovf;

    // Full-width add with carry into bit W.
    always_comb begin
        sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end

    // Overflow of the subtract form, and the gated outputs.
    always_comb begin
        ovf  = (a[MSB] == b_eff[MSB]) & (sum[MSB] != a[MSB]);
        lane = en ? sum[MSB:0] : '0;
        flag = cmp_signed ? (sum[MSB] ^ ovf) : sum[W];
    end

    // When disabled the lane contributes nothing to the merge.
    always_comb begin
        if (!en) begin
            AST_ADD_GATED: assert (lane == '0) // R3
                else $error("adder lane leaks while disabled");
        end
    end

endmodule

// File: rtl/alu_or_merge.sv
`timescale 1ns/1ps
// Module: alu_or_merge (top)
// Combinational ALU slice. Decodes the function code, runs the gated
// logic and adder lanes, and merges them with a bitwise OR. Assumes the
// caller registers the outputs; there is no clock or state.
module alu_or_merge
    import alu_or_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              carry_in,
    input  logic              rot_via_c,
    output logic [W-1:0]      result,
    output logic              carry_out,
    output logic              reg_wr_en,
    output logic              carry_wr_en
);

    alu_ctl_t     ctl;
    logic [W-1:0] b_eff;
    logic [W-1:0] logic_out;
    logic [W-1:0] add_out;
    logic         add_flag;

    alu_decoder i_dec (
        .func      (func),
        .rot_via_c (rot_via_c),
        .ctl       (ctl)
    );

    // Shared optional inversion of B.
    always_comb begin
        b_eff = ctl.neg ? ~op_b : op_b;
    end

    alu_logic_lane #(.W(W)) i_logic (
        .a       (op_a),
        .b_raw   (op_b),
        .b_eff   (b_eff),
        .and_en  (ctl.and_en),
        .xor_en  (ctl.xor_en),
        .pass_en (ctl.pass_en),
        .lane_or (logic_out)
    );

    alu_add_lane #(.W(W)) i_add (
        .a          (op_a),
        .b_eff      (b_eff),
        .cin        (ctl.neg),
        .en         (ctl.add_en),
        .cmp_signed (ctl.cmp_signed),
        .lane       (add_out),
        .flag       (add_flag)
    );

    // OR-merge of lanes and selection of the carry source.
    always_comb begin
        result      = logic_out | add_out;
        carry_out   = ctl.add_en ? add_flag : carry_in;
        reg_wr_en   = ctl.wb_en;
        carry_wr_en = ctl.cry_wr;
    end

    // Port-level rules tied to the function code.
    always_comb begin
        if (func inside {FN_SHIFT, FN_ROT, FN_IN, FN_OUT, FN_INV}) begin
            AST_CLEAR_ZERO: assert (result == '0) // R3
                else $error("clear code produced nonzero result");
        end
        if (func inside {FN_SET, FN_CALL, FN_LDC}) begin
            AST_PASS_B: assert (result == op_b) // R2
                else $error("pass code did not return B");
        end
        if (func inside {FN_CMPU, FN_CMPS, FN_OUT, FN_INV}) begin
            AST_NO_WB: assert (!reg_wr_en) // R7
                else $error("writeback on non-writing code");
        end
        if (carry_wr_en) begin
            AST_CRY_WR_CODES: assert (func[3:2] == 2'b01 || (func == FN_ROT && rot_via_c)) // R8
                else $error("carry write on wrong code");
        end
        if (func[2] == func[3]) begin
            AST_CARRY_HOLD: assert (carry_out == carry_in) // R9
                else $error("carry changed on non-arithmetic code");
        end
    end

endmodule

// File: tb/test_alu_or_merge.sv
`timescale 1ns/1ps
// Scoreboard bench: driver queues expected values, monitor compares them.
module test_alu_or_merge;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] a, b;
        logic [3:0]   f;
        logic [W-1:0] res;
        logic         co, wb, cw;
    } exp_t;

    logic clk = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [3:0]   func = '0;
    logic         carry_in = 1'b0, rot_via_c = 1'b0;
    logic [W-1:0] result;
    logic         carry_out, reg_wr_en, carry_wr_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    exp_t sb[$];

    always #2 clk = ~clk; // 250 MHz

    alu_or_merge #(.W(W)) i_alu_or_merge (
        .op_a(op_a), .op_b(op_b), .func(func), .carry_in(carry_in),
        .rot_via_c(rot_via_c), .result(result), .carry_out(carry_out),
        .reg_wr_en(reg_wr_en), .carry_wr_en(carry_wr_en)
    );

    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd8, 4'd9, 4'd12:      return "R2";
            4'd4:                   return "R5";
            4'd5:                   return "R6";
            4'd6, 4'd7:             return "R4";
            default:                return "R3";
        endcase
    endfunction

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [3:0] f, input logic ci, input logic rc);
        exp_t e;
        logic [W:0] s;
        e.a = a; e.b = b; e.f = f;
        e.res = '0; e.co = ci;
        case (f)
            4'd0: e.res = a | b;
            4'd1: e.res = a ^ b;
            4'd2: e.res = a & b;
            4'd3: e.res = a & ~b;
            4'd4, 4'd6: begin e.res = a - b; e.co = (a >= b); end
            4'd5: begin e.res = a - b; e.co = ($signed(a) < $signed(b)); end
            4'd7: begin s = {1'b0, a} + {1'b0, b}; e.res = s[W-1:0]; e.co = s[W]; end
            4'd8, 4'd9, 4'd12: e.res = b;
            default: e.res = '0;
        endcase
        e.wb = !(f inside {4'd4, 4'd5, 4'd14, 4'd15});
        e.cw = (f inside {4'd4, 4'd5, 4'd6, 4'd7}) || (f == 4'd11 && rc);
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply on the rising edge and queue the expectation.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] f, input logic ci, input logic rc);
        @(posedge clk);
        op_a = a; op_b = b; func = f; carry_in = ci; rot_via_c = rc;
        sb.push_back(model(a, b, f, ci, rc));
    endtask

    // Monitor: outputs are due in the same cycle; compare on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                string rq;
                e = sb.pop_front();
                rq = req_of(e.f);
                chk(result == e.res, rq, "result", result, e.res);
                chk(carry_out == e.co, (e.f[2] == e.f[3]) ? "R9" : rq, "carry_out",
                    {15'b0, carry_out}, {15'b0, e.co});
                chk(reg_wr_en == e.wb, "R7", "reg_wr_en", {15'b0, reg_wr_en}, {15'b0, e.wb});
                chk(carry_wr_en == e.cw, "R8", "carry_wr_en",
                    {15'b0, carry_wr_en}, {15'b0, e.cw});
            end
        end
    end

    logic [W-1:0] corners [4] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF};

    initial begin
        // Quiet state with zero inputs (R10: no state, result follows inputs).
        @(negedge clk);
        chk(result == '0, "R10", "idle result", result, '0);
        chk(reg_wr_en == 1'b1, "R7", "idle reg_wr_en", {15'b0, reg_wr_en}, 16'h1);
        // Corner sweep over every code.
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int k = 0; k < 2; k++)
                        drive(corners[i], corners[j], 4'(f), 1'(k), 1'(i ^ j ^ k));
        // Targeted compare and carry cases (R4, R5, R6).
        drive(16'h0005, 16'h0005, 4'd4, 1'b0, 1'b0);
        drive(16'h0004, 16'h0005, 4'd4, 1'b1, 1'b0);
        drive(16'hFFFF, 16'h0001, 4'd5, 1'b0, 1'b0);
        drive(16'h8000, 16'h7FFF, 4'd5, 1'b0, 1'b0);
        drive(16'h7FFF, 16'h8000, 4'd5, 1'b1, 1'b0);
        drive(16'hFFFF, 16'h0001, 4'd7, 1'b0, 1'b0);
        drive(16'h0001, 16'h0002, 4'd6, 1'b1, 1'b0);
        drive(16'h1234, 16'h00FF, 4'd11, 1'b1, 1'b1);
        drive(16'h1234, 16'h00FF, 4'd11, 1'b0, 1'b0);
        // Random sweep.
        for (int n = 0; n < 40; n++)
            for (int f = 0; f < 16; f++)
                drive(16'($urandom), 16'($urandom), 4'(f), 1'($urandom), 1'($urandom));
        @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule